// File: doc/BRIEF.md
# Speculation-Safe Set-Associative Cache

This block is a small set-associative cache, 4 ways by 16 sets with one 32-bit word per line. Its recency state cannot be moved by loads that run ahead of branch resolution. A load/store front end sends speculative reads. Each read carries a speculation tag naming the unresolved region it belongs to. The reply carries hit, data and the hitting way. It also carries the way that a fill to that set would evict next, so replacement state is visible at the ports. A read changes nothing inside the cache. A read that hits leaves a deferred touch record, holding set, way, stored line tag and speculation tag, in an 8-entry touch queue.

Resolution arrives on a separate plain control port. Accepting a tag arms all its queued records, and the queue then replays them into the age state one per cycle, oldest first. Rejecting a tag erases its queued records in a single cycle, so they leave no trace. Lines are installed by a fill request on the same request port, because refill from memory is outside this block. Misses only report.

Back-pressure: a request moves when `req_valid` and `req_ready` are both high. `req_ready` drops while the touch queue is full, or while an unaccepted response is held. A response moves when `resp_valid` and `resp_ready` are both high, and it stays stable until it moves. Only reads produce a response. A resolve applies to records already in the queue before that cycle. Address bits [1:0] are ignored, bits [5:2] select the set and bits [31:6] form the line tag.

Top module: `spec_cache`

## Requirements
- R1: A read accepted at a clock edge presents, after that edge, `resp_valid`=1 with `resp_hit`, and on a hit `resp_data` and `resp_way` of the matching way. At most one way ever matches.
- R2: A speculative read changes no tag, data, valid bit or age. The victim reported for a set is the same before and after any number of reads to that set.
- R3: A fill (`req_op`=1) to an address already present overwrites that way's data. Otherwise it writes into the victim way. In both cases the written way becomes the most recent.
- R4: After an accept for tag T, each queued hit with tag T causes exactly one recency touch of its way. Touches apply one per cycle in queue order, and never before the accept.
- R5: Each way keeps a 2-bit age, and the ages within a set are always a permutation of 0..3. A touch sets the touched way to 0 and increments every way that was younger than it. The victim is the lowest-numbered invalid way, or else the way with age 3. Reset clears all valid bits and sets the age of way w to w.
- R6: A reject for tag T removes every unaccepted queued record with tag T in one cycle. Those records never touch the age state.
- R7: The touch queue holds 8 records. `req_ready` is low whenever 8 records are queued.
- R8: A drained record whose line no longer holds the recorded line tag is dropped without changing any age.
- R9: While `resp_valid`=1 and `resp_ready`=0, the response is held stable and `req_ready` is low.
- R10: A fill takes the single age-update slot of its cycle. A pending drain waits one cycle and is not lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be taken |
| req_op | input | 1 | 0 speculative read, 1 fill |
| req_addr | input | 32 | Byte address |
| req_stag | input | 3 | Speculation tag of the read |
| req_wdata | input | 32 | Fill data |
| resp_valid | output | 1 | Response valid |
| resp_ready | input | 1 | Response consumer ready |
| resp_hit | output | 1 | Read hit |
| resp_data | output | 32 | Data of the hitting way |
| resp_way | output | 2 | Hitting way |
| resp_victim | output | 2 | Way a fill to this set would replace |
| rslv_valid | input | 1 | Resolve strobe |
| rslv_accept | input | 1 | 1 accept, 0 reject |
| rslv_stag | input | 3 | Speculation tag being resolved |

## Verification
The assertions check, on every cycle, several structural properties. The ages of the addressed set form a permutation. No two ways of a set match the same tag. A read with no drain pending never reaches the age update. The queue stays packed and never takes a record while full. No unaccepted record survives a reject of its tag. A stalled response is held stable. Only the bench's scenarios can show effects that span many cycles: a run of rejected reads leaves the victim unchanged, an accept shifts it by exactly the replayed touches, a record for a line replaced meanwhile is ignored, and a fill that collides with a drain delays the drain without losing it.

// File: rtl/spec_cache_pkg.sv
package spec_cache_pkg;
  typedef enum logic {
    OP_READ = 1'b0,
    OP_FILL = 1'b1
  } sc_op_e;
endpackage

// File: rtl/spc_tag_store.sv
module spc_tag_store #(
  parameter int WAYS   = 4,
  parameter int SETS   = 16,
  parameter int TAG_W  = 26,
  parameter int DATA_W = 32,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SET_W-1:0]  lk_set,
  input  logic [TAG_W-1:0]  lk_tag,
  output logic              lk_hit,
  output logic [WAY_W-1:0]  lk_way,
  output logic [DATA_W-1:0] lk_data,
  output logic [WAYS-1:0]   lk_valid,
  input  logic              wr_en,
  input  logic [SET_W-1:0]  wr_set,
  input  logic [WAY_W-1:0]  wr_way,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [SET_W-1:0]  pr_set,
  input  logic [WAY_W-1:0]  pr_way,
  output logic              pr_valid,
  output logic [TAG_W-1:0]  pr_tag
);
  logic [WAYS-1:0]   vld_q  [SETS];
  logic [TAG_W-1:0]  tag_q  [SETS][WAYS];
  logic [DATA_W-1:0] data_q [SETS][WAYS];
  logic [WAYS-1:0]   hit_vec;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = vld_q[lk_set][w] && (tag_q[lk_set][w] == lk_tag);
  end

  always_comb begin
    lk_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (hit_vec[w]) lk_way = WAY_W'(w);
    end
  end

  assign lk_hit   = |hit_vec;
  assign lk_data  = data_q[lk_set][lk_way];
  assign lk_valid = vld_q[lk_set];
  assign pr_valid = vld_q[pr_set][pr_way];
  assign pr_tag   = tag_q[pr_set][pr_way];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
    end else if (wr_en) begin
      vld_q[wr_set][wr_way] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_set][wr_way]  <= wr_tag;
      data_q[wr_set][wr_way] <= wr_data;
    end
  end

  // R1: a tag lives in at most one way of a set
  p_single_match_r1: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(hit_vec));
endmodule

// File: rtl/spc_lru_age.sv
module spc_lru_age #(
  parameter int WAYS = 4,
  parameter int SETS = 16,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int AGE_W = WAY_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] rd_set,
  input  logic [WAYS-1:0]  rd_valid,
  output logic [WAY_W-1:0] victim,
  input  logic             touch_en,
  input  logic [SET_W-1:0] touch_set,
  input  logic [WAY_W-1:0] touch_way
);
  logic [AGE_W-1:0] age_q [SETS][WAYS];
  logic [AGE_W-1:0] ref_age;

  assign ref_age = age_q[touch_set][touch_way];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) age_q[s][w] <= AGE_W'(w);
    end else if (touch_en) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == touch_way)
          age_q[touch_set][w] <= '0;
        else if (age_q[touch_set][w] < ref_age)
          age_q[touch_set][w] <= age_q[touch_set][w] + 1'b1;
      end
    end
  end

  always_comb begin
    logic found;
    found  = 1'b0;
    victim = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (!found && !rd_valid[w]) begin
        victim = WAY_W'(w);
        found  = 1'b1;
      end
    end
    if (!found) begin
      for (int w = 0; w < WAYS; w++) begin
        if (age_q[rd_set][w] == AGE_W'(WAYS - 1)) victim = WAY_W'(w);
      end
    end
  end

  logic [WAYS-1:0] seen;
  always_comb begin
    seen = '0;
    for (int w = 0; w < WAYS; w++) seen[age_q[rd_set][w]] = 1'b1;
  end

  // R5: ages inside the addressed set always form a permutation
  p_age_perm_r5: assert property (@(posedge clk) disable iff (!rst_n) &seen);
endmodule

// File: rtl/spc_touch_fifo.sv
module spc_touch_fifo #(
  parameter int DEPTH  = 8,
  parameter int SET_W  = 4,
  parameter int WAY_W  = 2,
  parameter int TAG_W  = 26,
  parameter int STAG_W = 3,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [SET_W-1:0]  push_set,
  input  logic [WAY_W-1:0]  push_way,
  input  logic [TAG_W-1:0]  push_ltag,
  input  logic [STAG_W-1:0] push_stag,
  input  logic              rs_valid,
  input  logic              rs_accept,
  input  logic [STAG_W-1:0] rs_stag,
  output logic              full,
  output logic              dr_valid,
  output logic [SET_W-1:0]  dr_set,
  output logic [WAY_W-1:0]  dr_way,
  output logic [TAG_W-1:0]  dr_ltag,
  input  logic              dr_take
);
  logic [DEPTH-1:0]  q_v, q_acc, n_v, n_acc;
  logic [SET_W-1:0]  q_set  [DEPTH], n_set  [DEPTH];
  logic [WAY_W-1:0]  q_way  [DEPTH], n_way  [DEPTH];
  logic [TAG_W-1:0]  q_ltag [DEPTH], n_ltag [DEPTH];
  logic [STAG_W-1:0] q_stag [DEPTH], n_stag [DEPTH];
  logic [IDX_W-1:0]  hd_idx;
  logic              hd_found;

  assign full = q_v[DEPTH-1];

  // oldest record already armed by an accept
  always_comb begin
    hd_found = 1'b0;
    hd_idx   = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (q_v[i] && q_acc[i]) begin
        hd_found = 1'b1;
        hd_idx   = IDX_W'(i);
      end
    end
  end

  assign dr_valid = hd_found;
  assign dr_set   = q_set[hd_idx];
  assign dr_way   = q_way[hd_idx];
  assign dr_ltag  = q_ltag[hd_idx];

  // compaction: survivors keep order, new record appended behind them
  always_comb begin
    logic [IDX_W:0] n;
    n     = '0;
    n_v   = '0;
    n_acc = '0;
    for (int i = 0; i < DEPTH; i++) begin
      n_set[i]  = '0;
      n_way[i]  = '0;
      n_ltag[i] = '0;
      n_stag[i] = '0;
    end
    for (int i = 0; i < DEPTH; i++) begin
      logic tmatch, keep;
      tmatch = rs_valid && (q_stag[i] == rs_stag);
      keep   = q_v[i] && !(dr_take && (IDX_W'(i) == hd_idx))
               && !(tmatch && !rs_accept && !q_acc[i]);
      if (keep) begin
        n_v[n[IDX_W-1:0]]    = 1'b1;
        n_acc[n[IDX_W-1:0]]  = q_acc[i] || (tmatch && rs_accept);
        n_set[n[IDX_W-1:0]]  = q_set[i];
        n_way[n[IDX_W-1:0]]  = q_way[i];
        n_ltag[n[IDX_W-1:0]] = q_ltag[i];
        n_stag[n[IDX_W-1:0]] = q_stag[i];
        n = n + 1'b1;
      end
    end
    if (push) begin
      n_v[n[IDX_W-1:0]]    = 1'b1;
      n_acc[n[IDX_W-1:0]]  = 1'b0;
      n_set[n[IDX_W-1:0]]  = push_set;
      n_way[n[IDX_W-1:0]]  = push_way;
      n_ltag[n[IDX_W-1:0]] = push_ltag;
      n_stag[n[IDX_W-1:0]] = push_stag;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_v   <= '0;
      q_acc <= '0;
    end else begin
      q_v   <= n_v;
      q_acc <= n_acc;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      q_set[i]  <= n_set[i];
      q_way[i]  <= n_way[i];
      q_ltag[i] <= n_ltag[i];
      q_stag[i] <= n_stag[i];
    end
  end

  logic [STAG_W-1:0] rej_tag_d;
  logic [DEPTH-1:0]  left_vec;
  always_ff @(posedge clk) rej_tag_d <= rs_stag;
  always_comb begin
    for (int i = 0; i < DEPTH; i++)
      left_vec[i] = q_v[i] && !q_acc[i] && (q_stag[i] == rej_tag_d);
  end

  // R7: never accepts a record while holding DEPTH of them
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n) push |-> !full);
  // R7: occupied slots stay packed at the low end
  p_packed_r7: assert property (@(posedge clk) disable iff (!rst_n) (q_v & (q_v + 1'b1)) == '0);
  // R4: a drain is only taken from an armed record
  p_take_armed_r4: assert property (@(posedge clk) disable iff (!rst_n) dr_take |-> dr_valid);
  // R6: a reject leaves no unarmed record of its tag
  p_reject_purge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && !rs_accept && !(push && push_stag == rs_stag)) |=> left_vec == '0);
endmodule

// File: rtl/spec_cache.sv
module spec_cache
  import spec_cache_pkg::*;
#(
  parameter int WAYS   = 4,
  parameter int SETS   = 16,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int STAG_W = 3,
  parameter int QDEPTH = 8,
  localparam int WAY_W = $clog2(WAYS),
  localparam int SET_W = $clog2(SETS),
  localparam int OFF_W = 2,
  localparam int TAG_W = ADDR_W - SET_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [STAG_W-1:0] req_stag,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              resp_valid,
  input  logic              resp_ready,
  output logic              resp_hit,
  output logic [DATA_W-1:0] resp_data,
  output logic [WAY_W-1:0]  resp_way,
  output logic [WAY_W-1:0]  resp_victim,
  input  logic              rslv_valid,
  input  logic              rslv_accept,
  input  logic [STAG_W-1:0] rslv_stag
);
  logic [SET_W-1:0]  req_set;
  logic [TAG_W-1:0]  req_tag;
  logic              req_fire, is_fill, wr_en, push;
  logic              lk_hit;
  logic [WAY_W-1:0]  lk_way, victim, fill_way;
  logic [DATA_W-1:0] lk_data;
  logic [WAYS-1:0]   lk_valid;
  logic              q_full, dr_valid, dr_take, pr_valid, drain_touch, touch_en;
  logic [SET_W-1:0]  dr_set;
  logic [WAY_W-1:0]  dr_way;
  logic [TAG_W-1:0]  dr_ltag, pr_tag;

  assign req_set  = req_addr[OFF_W +: SET_W];
  assign req_tag  = req_addr[ADDR_W-1 -: TAG_W];
  assign req_ready = !q_full && (!resp_valid || resp_ready);
  assign req_fire = req_valid && req_ready;
  assign is_fill  = (sc_op_e'(req_op) == OP_FILL);
  assign wr_en    = req_fire && is_fill;
  assign fill_way = lk_hit ? lk_way : victim;
  assign push     = req_fire && !is_fill && lk_hit;

  // the single age-update slot: a fill wins, a drain waits
  assign dr_take     = dr_valid && !wr_en;
  assign drain_touch = dr_take && pr_valid && (pr_tag == dr_ltag);
  assign touch_en    = wr_en || drain_touch;

  spc_tag_store #(.WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_set   (req_set),
    .lk_tag   (req_tag),
    .lk_hit   (lk_hit),
    .lk_way   (lk_way),
    .lk_data  (lk_data),
    .lk_valid (lk_valid),
    .wr_en    (wr_en),
    .wr_set   (req_set),
    .wr_way   (fill_way),
    .wr_tag   (req_tag),
    .wr_data  (req_wdata),
    .pr_set   (dr_set),
    .pr_way   (dr_way),
    .pr_valid (pr_valid),
    .pr_tag   (pr_tag)
  );

  spc_lru_age #(.WAYS(WAYS), .SETS(SETS)) u_age (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_set    (req_set),
    .rd_valid  (lk_valid),
    .victim    (victim),
    .touch_en  (touch_en),
    .touch_set (wr_en ? req_set : dr_set),
    .touch_way (wr_en ? fill_way : dr_way)
  );

  spc_touch_fifo #(.DEPTH(QDEPTH), .SET_W(SET_W), .WAY_W(WAY_W), .TAG_W(TAG_W),
                   .STAG_W(STAG_W)) u_queue (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .push_set  (req_set),
    .push_way  (lk_way),
    .push_ltag (req_tag),
    .push_stag (req_stag),
    .rs_valid  (rslv_valid),
    .rs_accept (rslv_accept),
    .rs_stag   (rslv_stag),
    .full      (q_full),
    .dr_valid  (dr_valid),
    .dr_set    (dr_set),
    .dr_way    (dr_way),
    .dr_ltag   (dr_ltag),
    .dr_take   (dr_take)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
    end else if (req_fire) begin
      resp_valid <= !is_fill;
    end else if (resp_ready) begin
      resp_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (req_fire && !is_fill) begin
      resp_hit    <= lk_hit;
      resp_data   <= lk_data;
      resp_way    <= lk_way;
      resp_victim <= victim;
    end
  end

  // R2: a read with nothing armed in the queue never reaches the age state
  p_spec_read_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_fire && !is_fill && !dr_valid) |-> !touch_en);
  // R9: a stalled response holds still
  p_resp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_ready) |=> (resp_valid && $stable(resp_hit) && $stable(resp_data)
                                     && $stable(resp_way) && $stable(resp_victim)));
  // R7: full queue blocks new requests
  p_full_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n) q_full |-> !req_fire);
endmodule

// File: tb/spec_cache_tb.sv
module spec_cache_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_op = 1'b0, resp_ready = 1'b1;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic [2:0]  req_stag = '0, rslv_stag = '0;
  logic        rslv_valid = 1'b0, rslv_accept = 1'b0;
  logic        req_ready, resp_valid, resp_hit;
  logic [31:0] resp_data;
  logic [1:0]  resp_way, resp_victim;

  always #4 clk = ~clk;

  spec_cache u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_stag(req_stag), .req_wdata(req_wdata),
    .resp_valid(resp_valid), .resp_ready(resp_ready), .resp_hit(resp_hit),
    .resp_data(resp_data), .resp_way(resp_way), .resp_victim(resp_victim),
    .rslv_valid(rslv_valid), .rslv_accept(rslv_accept), .rslv_stag(rslv_stag)
  );

  int n_chk = 0, n_bad = 0, cyc_cnt = 0;

  // reference state built from the requirements
  bit        mv [16][4];
  bit [25:0] mt [16][4];
  bit [31:0] md [16][4];
  int        ma [16][4];
  typedef struct { int s; int w; bit [25:0] lt; int st; bit acc; } qe_t;
  qe_t mq[$];
  bit        e_rv = 0, e_hit = 0;
  bit [31:0] e_data = 0;
  int        e_way = 0, e_vic = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  function automatic void m_touch(int s, int w);
    int ref_a = ma[s][w];
    for (int o = 0; o < 4; o++) if (o != w && ma[s][o] < ref_a) ma[s][o]++;
    ma[s][w] = 0;
  endfunction

  function automatic int m_victim(int s);
    for (int w = 0; w < 4; w++) if (!mv[s][w]) return w;
    for (int w = 0; w < 4; w++) if (ma[s][w] == 3) return w;
    return 0;
  endfunction

  function automatic bit [31:0] adr(int s, int t);
    return {t[25:0], s[3:0], 2'b00};
  endfunction

  task automatic cyc(input bit v, input bit op, input bit [31:0] a, input int st,
                     input bit [31:0] wd, input bit rv, input bit ra, input int rt,
                     input bit rr, input string rq);
    bit exp_rdy, fire, fill, drain;
    int s, hw, vic, h;
    bit [25:0] t;
    qe_t nq[$];
    @(negedge clk);
    req_valid = v; req_op = op; req_addr = a; req_stag = 3'(st); req_wdata = wd;
    rslv_valid = rv; rslv_accept = ra; rslv_stag = 3'(rt); resp_ready = rr;
    #1;
    exp_rdy = (mq.size() < 8) && (!e_rv || rr);
    chk(req_ready == exp_rdy, (mq.size() >= 8) ? "R7" : rq, "req_ready", req_ready, exp_rdy);
    fire = v && req_ready;
    fill = fire && op;
    s = int'(a[5:2]); t = a[31:6];
    hw = -1;
    for (int w = 0; w < 4; w++) if (mv[s][w] && mt[s][w] == t) hw = w;
    vic = m_victim(s);
    h = -1;
    for (int i = mq.size() - 1; i >= 0; i--) if (mq[i].acc) h = i;
    drain = (h >= 0) && !fill;
    for (int i = 0; i < mq.size(); i++) begin
      qe_t e = mq[i];
      bit tm = rv && (e.st == rt);
      if (drain && i == h) continue;
      if (tm && !ra && !e.acc) continue;
      e.acc = e.acc || (tm && ra);
      nq.push_back(e);
    end
    if (drain && mv[mq[h].s][mq[h].w] && mt[mq[h].s][mq[h].w] == mq[h].lt)
      m_touch(mq[h].s, mq[h].w);
    if (fill) begin
      int w = (hw >= 0) ? hw : vic;
      mv[s][w] = 1; mt[s][w] = t; md[s][w] = wd;
      m_touch(s, w);
    end
    if (fire && !op && hw >= 0) begin
      qe_t e;
      e.s = s; e.w = hw; e.lt = t; e.st = st; e.acc = 0;
      nq.push_back(e);
    end
    mq = nq;
    if (fire) begin
      e_rv = !op;
      if (!op) begin
        e_hit = (hw >= 0); e_vic = vic;
        if (hw >= 0) begin e_way = hw; e_data = md[s][hw]; end
      end
    end else if (rr) e_rv = 0;
    @(posedge clk); #1;
    chk(resp_valid == e_rv, rq, "resp_valid", resp_valid, e_rv);
    if (e_rv) begin
      chk(resp_hit == e_hit, rq, "resp_hit", resp_hit, e_hit);
      chk(int'(resp_victim) == e_vic, rq, "resp_victim", resp_victim, e_vic);
      if (e_hit) begin
        chk(int'(resp_way) == e_way, rq, "resp_way", resp_way, e_way);
        chk(resp_data == e_data, rq, "resp_data", resp_data, e_data);
      end
    end
  endtask

  task automatic idle(input int n, input string rq);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, rq);
  endtask

  task automatic rd(input int s, input int t, input int st, input string rq);
    cyc(1, 0, adr(s, t), st, 0, 0, 0, 0, 1, rq);
  endtask

  task automatic fl(input int s, input int t, input bit [31:0] d, input string rq);
    cyc(1, 1, adr(s, t), 0, d, 0, 0, 0, 1, rq);
  endtask

  task automatic rslv(input bit ra, input int rt, input string rq);
    cyc(0, 0, 0, 0, 0, 1, ra, rt, 1, rq);
  endtask

  initial begin
    for (int s = 0; s < 16; s++)
      for (int w = 0; w < 4; w++) begin mv[s][w] = 0; mt[s][w] = 0; md[s][w] = 0; ma[s][w] = w; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    // R5: reset state
    chk(resp_valid == 0, "R5", "reset resp_valid", resp_valid, 0);
    chk(req_ready == 1, "R5", "reset req_ready", req_ready, 1);

    rd(3, 1, 0, "R1");                       // miss, victim way 0
    chk(resp_victim == 0, "R5", "empty set victim", resp_victim, 0);
    for (int k = 1; k <= 4; k++) fl(3, k, 32'hA000 + k, "R3");
    for (int k = 1; k <= 4; k++) rd(3, k, 0, "R1");
    rslv(0, 0, "R6");
    fl(3, 2, 32'hBEEF, "R3");                 // overwrite in place
    rd(3, 2, 0, "R3");
    chk(resp_data == 32'hBEEF && resp_way == 1, "R3", "overwrite", resp_data, 32'hBEEF);
    rslv(0, 0, "R6");

    // R2/R6: rejected reads leave the victim choice as it was
    begin
      int v0;
      rd(3, 3, 0, "R2");
      v0 = int'(resp_victim);
      rslv(0, 0, "R6");
      for (int i = 0; i < 5; i++) rd(3, (i % 4) + 1, 2, "R2");
      rslv(0, 2, "R6");
      idle(2, "R6");
      rd(3, 4, 1, "R6");
      chk(int'(resp_victim) == v0, "R6", "victim after rejects", resp_victim, v0);
      rslv(0, 1, "R6");
    end

    // R4: accepted read moves the victim
    begin
      int v0;
      rd(3, 3, 0, "R4");
      v0 = int'(resp_victim);
      rslv(0, 0, "R4");
      rd(3, mt[3][v0], 5, "R4");
      rslv(1, 5, "R4");
      idle(3, "R4");
      rd(3, 1, 0, "R4");
      chk(int'(resp_victim) != v0, "R4", "victim moved", resp_victim, v0);
      rslv(0, 0, "R4");
    end

    // R8: record whose line got replaced is skipped
    begin
      int v0;
      rd(3, 1, 0, "R8"); v0 = e_vic; rslv(0, 0, "R8");
      rd(3, mt[3][v0], 6, "R8");
      fl(3, 9, 32'h99, "R8");
      rslv(1, 6, "R8");
      idle(3, "R8");
      rd(3, 9, 0, "R8");
      rslv(0, 0, "R8");
    end

    // R10: fill collides with an armed drain
    rd(5, 1, 0, "R10"); rslv(0, 0, "R10");
    fl(3, 1, 32'h11, "R10");
    rd(3, 1, 4, "R10");
    rslv(1, 4, "R10");
    fl(5, 7, 32'h77, "R10");
    idle(2, "R10");
    rd(3, 9, 0, "R10"); rslv(0, 0, "R10");

    // R7: queue fills up and blocks
    for (int i = 0; i < 9; i++) rd(3, 9, 7, "R7");
    rslv(0, 7, "R7");
    idle(1, "R7");

    // R9: response back-pressure
    cyc(1, 0, adr(3, 9), 0, 0, 0, 0, 0, 0, "R9");
    cyc(1, 0, adr(3, 1), 0, 0, 0, 0, 0, 0, "R9");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, "R9");
    rslv(0, 0, "R9");

    // random mix
    void'($urandom(32'd1234));
    for (int i = 0; i < 4000; i++) begin
      int r = int'($urandom_range(0, 99));
      bit v = (r < 70);
      bit op = ($urandom_range(0, 9) < 3);
      int s = int'($urandom_range(0, 3));
      int t = int'($urandom_range(0, 6));
      bit rv = ($urandom_range(0, 9) < 3);
      cyc(v, op, adr(s, t), int'($urandom_range(0, 3)), $urandom, rv,
          1'($urandom_range(0, 1)), int'($urandom_range(0, 3)),
          ($urandom_range(0, 9) < 9), "R4");
    end
    idle(10, "R4");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cyc_cnt++;
      if (cyc_cnt > 150000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc_cnt, 150000);
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
      end
    end
  end
endmodule